// File: doc/BRIEF.md
# Lockable Two-Way Read Cache

This block is a 4 KB read cache with two ways of 128 sets each, holding 16-byte lines. It sits between a 32-bit processor read port and a memory port that delivers whole lines one word at a time. A read that hits is answered in the same cycle. A read that misses fetches the line in four ascending beats. The processor is released on the beat that carries the word it asked for, and the line is allocated into the way chosen by the replacement logic.

Replacement follows a per-set least-recently-used bit. A per-line lock bit, set and cleared through a separate maintenance port, overrides that choice, so locked lines stay resident. When both ways of a set are locked, a miss is still served from memory but nothing is allocated. Processor writes are not stored. A write that hits only invalidates the line. All addresses on the ports are word addresses (byte address bits 31:2), so the index and tag come straight from the physical address.

Top module: `lcache`

## Requirements
- R1: `cpuAddr` is a word address: bits [1:0] select the word, bits [8:2] the set and bits [29:9] the tag. A read that hits raises `cpuReady` in the same cycle as `cpuReq`, returns the stored word on `cpuRdata` and does not raise `memReq`.
- R2: A read miss raises `memReq` from the next cycle with `memLine` equal to `cpuAddr[29:2]`, and holds it until four `memValid` beats (words 0 to 3 in order) have been taken. `cpuReady` pulses only on the beat whose number equals the requested word, with `cpuRdata` equal to `memData`.
- R3: After an allocating fill, every word of that line hits.
- R4: Each set has an LRU bit that is cleared by reset, so way 0 is the first victim. A hit or a fill in way w makes the other way the next victim.
- R5: Maintenance op 1 (lock) sets the lock bit of line (`mntIndex`, `mntWay`). A locked line is never chosen as victim. With exactly one way of a set locked, the other way is the victim whatever the LRU bit holds.
- R6: If both ways of the set are locked, a miss is served from memory as in R2 but nothing is allocated, so a repeated read misses again.
- R7: Maintenance op 2 (unlock) clears the lock bit and makes the line replaceable again.
- R8: Maintenance op 3 (invalidate) clears both the valid bit and the lock bit of the addressed line. Op 0 does nothing.
- R9: A processor write (`cpuWr`=1) is acknowledged in the same cycle without any memory access. If it hits, it invalidates that line and clears its lock bit. If it misses, the cache contents are left unchanged.
- R10: `mntReady` is high only while no fill is in progress. A `mntValid` request takes priority over a processor request in the same cycle, and that processor request waits.
- R11: After reset no line is valid or locked, `memReq` and `cpuReady` are low and `mntReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until `cpuReady` |
| cpuWr | input | 1 | Request is a write (invalidate on hit) |
| cpuAddr | input | ADDR_W-2 | Processor word address |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` |
| cpuReady | output | 1 | Request completes this cycle |
| memReq | output | 1 | Line fill in progress |
| memLine | output | LINE_W | Line address of the fill |
| memValid | input | 1 | Fill beat present on `memData` |
| memData | input | DATA_W | Fill word |
| mntValid | input | 1 | Maintenance request |
| mntOp | input | 2 | 0 none, 1 lock, 2 unlock, 3 invalidate |
| mntIndex | input | IDX_W | Set addressed by maintenance |
| mntWay | input | 1 | Way addressed by maintenance |
| mntReady | output | 1 | Controller idle, maintenance applied |

## Verification
The assertions check on every cycle that at most one way hits, that a locked line is never written by a fill, that a set with both ways locked never allocates, that a hit moves the LRU bit away from the way that hit, and that an invalidate clears both valid and lock. They also check that the memory request is held through the burst and that a ready during a fill coincides with a memory beat. Which way a miss actually evicts, the effect of lock, unlock and invalidate on later replacements, no-allocate reads, and write invalidation can only be seen through the bench's sequences of hits and misses on one set.

// File: rtl/lcache_pkg.sv
`timescale 1ns/1ps
package lcache_pkg;

  typedef enum logic [1:0] {
    MNT_NOP    = 2'd0,
    MNT_LOCK   = 2'd1,
    MNT_UNLOCK = 2'd2,
    MNT_INVAL  = 2'd3
  } mntOp_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic lruTouch;   // hit: update set LRU
    logic wrInval;    // write hit: drop the line
    logic fillStart;  // miss: latch line address and victim
    logic fillWrite;  // fill beat: store the word
    logic fillDone;   // last beat: set tag and valid
    logic mntApply;   // apply maintenance op
    logic fwdMem;     // route memory word to the processor
  } strobes_t;

endpackage

// File: rtl/lcache_dp.sv
`timescale 1ns/1ps
module lcache_dp
  import lcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(SETS),
  parameter int LINE_W = ADDR_W - 2 - $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [ADDR_W-3:0] cpuAddr,
  input  logic [$clog2(WORDS)-1:0] fillBeat,
  input  logic [DATA_W-1:0] memData,
  input  mntOp_e            mntOp,
  input  logic [IDX_W-1:0]  mntIndex,
  input  logic              mntWay,
  output logic              hit,
  output logic [DATA_W-1:0] hitData,
  output logic [LINE_W-1:0] memLine
);

  localparam int WAYS   = 2;
  localparam int WORD_W = $clog2(WORDS);
  localparam int TAG_W  = LINE_W - IDX_W;

  logic [TAG_W-1:0]  cpuTag;
  logic [IDX_W-1:0]  cpuIdx;
  logic [WORD_W-1:0] cpuWord;
  assign cpuWord = cpuAddr[WORD_W-1:0];
  assign cpuIdx  = cpuAddr[WORD_W +: IDX_W];
  assign cpuTag  = cpuAddr[ADDR_W-3 -: TAG_W];

  // fill context latched at the miss
  logic [LINE_W-1:0] fillLine;
  logic              fillWay;
  logic              fillAlloc;
  logic [IDX_W-1:0]  fillIdx;
  logic [TAG_W-1:0]  fillTag;
  assign fillIdx = fillLine[IDX_W-1:0];
  assign fillTag = fillLine[LINE_W-1 -: TAG_W];
  assign memLine = fillLine;

  logic [WAYS-1:0]   hitVec;
  logic [WAYS-1:0]   lockAtIdx;
  logic [WAYS-1:0]   lockAtFill;
  logic [DATA_W-1:0] wayData [WAYS];
  logic [SETS-1:0]   lruBits;
  logic              hitWay;
  logic              victimWay;
  logic              bothLocked;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tagMem  [SETS];
    logic [DATA_W-1:0] dataMem [SETS*WORDS];
    logic [SETS-1:0]   validBits;
    logic [SETS-1:0]   lockBits;
    logic              fillHere;
    logic              mntHere;

    assign fillHere = fillAlloc && (fillWay == 1'(w));
    assign mntHere  = st.mntApply && (mntWay == 1'(w));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validBits <= '0;
        lockBits  <= '0;
      end else begin
        if (st.wrInval && hitVec[w]) begin
          validBits[cpuIdx] <= 1'b0;
          lockBits[cpuIdx]  <= 1'b0;
        end
        if (mntHere) begin
          case (mntOp)
            MNT_LOCK:   lockBits[mntIndex] <= 1'b1;
            MNT_UNLOCK: lockBits[mntIndex] <= 1'b0;
            MNT_INVAL: begin
              validBits[mntIndex] <= 1'b0;
              lockBits[mntIndex]  <= 1'b0;
            end
            default: ;
          endcase
        end
        if (st.fillDone && fillHere) validBits[fillIdx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (st.fillWrite && fillHere) dataMem[{fillIdx, fillBeat}] <= memData;
      if (st.fillDone && fillHere)  tagMem[fillIdx] <= fillTag;
    end

    assign hitVec[w]     = validBits[cpuIdx] && (tagMem[cpuIdx] == cpuTag);
    assign wayData[w]    = dataMem[{cpuIdx, cpuWord}];
    assign lockAtIdx[w]  = lockBits[cpuIdx];
    assign lockAtFill[w] = lockBits[fillIdx];

    // R8: invalidate leaves the line neither valid nor locked
    a_r8_inval_clears: assert property (@(posedge clk) disable iff (!rstN)
      (mntHere && mntOp == MNT_INVAL) |=>
        (!validBits[$past(mntIndex)] && !lockBits[$past(mntIndex)]));
  end

  assign hit        = |hitVec;
  assign hitWay     = hitVec[1];
  assign hitData    = hitVec[1] ? wayData[1] : wayData[0];
  assign bothLocked = &lockAtIdx;

  // lock overrides LRU; with both locked the choice is unused
  always_comb begin
    if (lockAtIdx[0])      victimWay = 1'b1;
    else if (lockAtIdx[1]) victimWay = 1'b0;
    else                   victimWay = lruBits[cpuIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lruBits   <= '0;
      fillLine  <= '0;
      fillWay   <= 1'b0;
      fillAlloc <= 1'b0;
    end else begin
      if (st.lruTouch) lruBits[cpuIdx] <= ~hitWay;
      if (st.fillDone && fillAlloc) lruBits[fillIdx] <= ~fillWay;
      if (st.fillStart) begin
        fillLine  <= cpuAddr[ADDR_W-3:WORD_W];
        fillWay   <= victimWay;
        fillAlloc <= ~bothLocked;
      end
    end
  end

  // R1: a line is present in at most one way
  a_r1_single_way_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R5: a fill never writes into a locked line
  a_r5_no_fill_locked: assert property (@(posedge clk) disable iff (!rstN)
    (st.fillWrite && fillAlloc) |-> !lockAtFill[fillWay]);

  // R6: a fully locked set is served without allocation
  a_r6_no_alloc: assert property (@(posedge clk) disable iff (!rstN)
    (st.fillStart && bothLocked) |=> !fillAlloc);

  // R4: a hit points the set's victim at the other way
  a_r4_lru_moves: assert property (@(posedge clk) disable iff (!rstN)
    st.lruTouch |=> (lruBits[$past(cpuIdx)] == !$past(hitWay)));

endmodule

// File: rtl/lcache_ctrl.sv
`timescale 1ns/1ps
module lcache_ctrl
  import lcache_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWr,
  input  logic [$clog2(WORDS)-1:0] cpuWord,
  input  logic                     hit,
  input  logic                     memValid,
  input  logic                     mntValid,
  output strobes_t                 st,
  output logic [$clog2(WORDS)-1:0] fillBeat,
  output logic                     cpuReady,
  output logic                     memReq,
  output logic                     mntReady
);

  localparam int WORD_W = $clog2(WORDS);
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

  typedef enum logic {S_IDLE, S_FILL} state_e;

  state_e            state, stateNext;
  logic [WORD_W-1:0] beat;
  logic [WORD_W-1:0] critWord;

  assign fillBeat = beat;
  assign memReq   = (state == S_FILL);
  assign mntReady = (state == S_IDLE);

  always_comb begin
    st        = '0;
    cpuReady  = 1'b0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (mntValid) begin
          st.mntApply = 1'b1;
        end else if (cpuReq) begin
          if (cpuWr) begin
            cpuReady   = 1'b1;
            st.wrInval = hit;
          end else if (hit) begin
            cpuReady    = 1'b1;
            st.lruTouch = 1'b1;
          end else begin
            st.fillStart = 1'b1;
            stateNext    = S_FILL;
          end
        end
      end
      S_FILL: begin
        if (memValid) begin
          st.fillWrite = 1'b1;
          if (beat == critWord) begin
            cpuReady  = 1'b1;
            st.fwdMem = 1'b1;
          end
          if (beat == LAST_BEAT) begin
            st.fillDone = 1'b1;
            stateNext   = S_IDLE;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      beat     <= '0;
      critWord <= '0;
    end else begin
      state <= stateNext;
      if (st.fillStart) begin
        beat     <= '0;
        critWord <= cpuWord;
      end else if (state == S_FILL && memValid) begin
        beat <= beat + 1'b1;
      end
    end
  end

  // R2: during a fill the processor is released only on a memory beat
  a_r2_ready_on_beat: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL && cpuReady) |-> memValid);

  // R2: the memory request stays up until the last beat is taken
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL && !(memValid && beat == LAST_BEAT)) |=> memReq);

  // R10: maintenance is never applied while a fill is running
  a_r10_mnt_idle: assert property (@(posedge clk) disable iff (!rstN)
    st.mntApply |-> !memReq);

  // R9: writes complete at once and never start a fill
  a_r9_write_no_fill: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuWr && mntReady && !mntValid) |-> (cpuReady && !st.fillStart));

endmodule

// File: rtl/lcache.sv
`timescale 1ns/1ps
module lcache
  import lcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(SETS),
  parameter int LINE_W = ADDR_W - 2 - $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWr,
  input  logic [ADDR_W-3:0] cpuAddr,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic [LINE_W-1:0] memLine,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memData,
  input  logic              mntValid,
  input  logic [1:0]        mntOp,
  input  logic [IDX_W-1:0]  mntIndex,
  input  logic              mntWay,
  output logic              mntReady
);

  localparam int WORD_W = $clog2(WORDS);

  strobes_t          st;
  logic [WORD_W-1:0] fillBeat;
  logic              hit;
  logic [DATA_W-1:0] hitData;

  lcache_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWr    (cpuWr),
    .cpuWord  (cpuAddr[WORD_W-1:0]),
    .hit      (hit),
    .memValid (memValid),
    .mntValid (mntValid),
    .st       (st),
    .fillBeat (fillBeat),
    .cpuReady (cpuReady),
    .memReq   (memReq),
    .mntReady (mntReady)
  );

  lcache_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SETS   (SETS),
    .WORDS  (WORDS),
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .cpuAddr  (cpuAddr),
    .fillBeat (fillBeat),
    .memData  (memData),
    .mntOp    (mntOp_e'(mntOp)),
    .mntIndex (mntIndex),
    .mntWay   (mntWay),
    .hit      (hit),
    .hitData  (hitData),
    .memLine  (memLine)
  );

  assign cpuRdata = st.fwdMem ? memData : hitData;

endmodule

// File: tb/lcache_tb.sv
`timescale 1ns/1ps
module lcache_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWr = 1'b0;
  logic [29:0] cpuAddr = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        memReq;
  logic [27:0] memLine;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;
  logic        mntValid = 1'b0;
  logic [1:0]  mntOp = 2'd0;
  logic [6:0]  mntIndex = '0;
  logic        mntWay = 1'b0;
  logic        mntReady;

  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  lcache u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuRdata(cpuRdata), .cpuReady(cpuReady), .memReq(memReq), .memLine(memLine),
    .memValid(memValid), .memData(memData), .mntValid(mntValid), .mntOp(mntOp),
    .mntIndex(mntIndex), .mntWay(mntWay), .mntReady(mntReady)
  );

  typedef struct packed {
    logic [2:0] op;    // 0 read, 1 write, 2 lock, 3 unlock, 4 invalidate
    logic [7:0] tag;
    logic [6:0] idx;
    logic [1:0] word;
    logic       way;
    logic       miss;
  } vec_t;

  localparam int NVEC = 37;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 8'd1, 7'd5, 2'd2, 1'b0, 1'b1},  // R2 first miss -> way0
    '{3'd0, 8'd1, 7'd5, 2'd0, 1'b0, 1'b0},  // R3
    '{3'd0, 8'd1, 7'd5, 2'd3, 1'b0, 1'b0},  // R3
    '{3'd0, 8'd2, 7'd5, 2'd1, 1'b0, 1'b1},  // -> way1
    '{3'd0, 8'd1, 7'd5, 2'd1, 1'b0, 1'b0},  // R4 touch way0
    '{3'd0, 8'd3, 7'd5, 2'd0, 1'b0, 1'b1},  // R4 evicts tag 2
    '{3'd0, 8'd3, 7'd5, 2'd2, 1'b0, 1'b0},
    '{3'd0, 8'd2, 7'd5, 2'd3, 1'b0, 1'b1},  // R4 tag 2 gone, -> way0
    '{3'd2, 8'd0, 7'd5, 2'd0, 1'b0, 1'b0},  // R5 lock way0
    '{3'd0, 8'd3, 7'd5, 2'd1, 1'b0, 1'b0},  // LRU now points at way0
    '{3'd0, 8'd4, 7'd5, 2'd0, 1'b0, 1'b1},  // R5 forced to way1
    '{3'd0, 8'd2, 7'd5, 2'd2, 1'b0, 1'b0},  // R5 locked line stays
    '{3'd0, 8'd3, 7'd5, 2'd0, 1'b0, 1'b1},
    '{3'd2, 8'd0, 7'd5, 2'd0, 1'b1, 1'b0},  // lock way1
    '{3'd0, 8'd1, 7'd5, 2'd1, 1'b0, 1'b1},  // R6 no allocate
    '{3'd0, 8'd1, 7'd5, 2'd1, 1'b0, 1'b1},  // R6 misses again
    '{3'd0, 8'd2, 7'd5, 2'd0, 1'b0, 1'b0},
    '{3'd0, 8'd3, 7'd5, 2'd3, 1'b0, 1'b0},
    '{3'd3, 8'd0, 7'd5, 2'd0, 1'b0, 1'b0},  // R7 unlock way0
    '{3'd0, 8'd1, 7'd5, 2'd0, 1'b0, 1'b1},  // R7 -> way0
    '{3'd0, 8'd2, 7'd5, 2'd2, 1'b0, 1'b1},  // R5 LRU says way1, lock forces way0
    '{3'd4, 8'd0, 7'd5, 2'd0, 1'b1, 1'b0},  // R8 invalidate way1
    '{3'd0, 8'd3, 7'd5, 2'd1, 1'b0, 1'b1},  // R8 lock gone -> way1
    '{3'd0, 8'd2, 7'd5, 2'd0, 1'b0, 1'b0},  // R8 way0 untouched
    '{3'd1, 8'd2, 7'd5, 2'd0, 1'b0, 1'b0},  // R9 write hit invalidates
    '{3'd0, 8'd2, 7'd5, 2'd3, 1'b0, 1'b1},  // R9 now a miss
    '{3'd0, 8'd3, 7'd5, 2'd2, 1'b0, 1'b1},
    '{3'd2, 8'd0, 7'd5, 2'd0, 1'b1, 1'b0},  // lock way1
    '{3'd1, 8'd2, 7'd5, 2'd0, 1'b0, 1'b0},  // R9 write clears lock
    '{3'd0, 8'd1, 7'd5, 2'd0, 1'b0, 1'b1},  // R9 -> way1 since unlocked
    '{3'd0, 8'd3, 7'd5, 2'd1, 1'b0, 1'b0},
    '{3'd1, 8'd4, 7'd5, 2'd0, 1'b0, 1'b0},  // R9 write miss no effect
    '{3'd0, 8'd1, 7'd5, 2'd2, 1'b0, 1'b0},
    '{3'd0, 8'd3, 7'd5, 2'd0, 1'b0, 1'b0},
    '{3'd0, 8'd1, 7'd6, 2'd1, 1'b0, 1'b1},  // R1 other set
    '{3'd0, 8'd1, 7'd6, 2'd0, 1'b0, 1'b0},
    '{3'd0, 8'd3, 7'd5, 2'd3, 1'b0, 1'b0}
  };

  function automatic logic [31:0] memWord(input logic [29:0] wa);
    return {wa[15:0], wa[29:14]} ^ 32'h6B2D_91E7;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [7:0] tg, input logic [6:0] ix,
                        input logic [1:0] wd, input logic expMiss);
    logic [29:0] a;
    a = {13'd0, tg, ix, wd};
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = 1'b0; cpuAddr = a;
    #1;
    chk(expMiss ? "R4 miss expected" : "R1 hit expected", {31'd0, cpuReady}, {31'd0, !expMiss});
    chk("R1 no memReq in lookup", {31'd0, memReq}, 32'd0);
    if (!expMiss) begin
      chk("R1 hit data", cpuRdata, memWord(a));
      @(negedge clk);
      cpuReq = 1'b0;
    end else begin
      @(negedge clk);
      #1;
      chk("R2 memReq raised", {31'd0, memReq}, 32'd1);
      chk("R2 line address", {4'd0, memLine}, {4'd0, a[29:2]});
      chk("R10 busy during fill", {31'd0, mntReady}, 32'd0);
      chk("R2 stalled before beat", {31'd0, cpuReady}, 32'd0);
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
        memValid = 1'b1;
        memData  = memWord({a[29:2], 2'(b)});
        #1;
        chk("R2 ready on critical beat", {31'd0, cpuReady}, {31'd0, (2'(b) == wd)});
        if (2'(b) == wd) chk("R2 forwarded word", cpuRdata, memWord(a));
        @(negedge clk);
        if (2'(b) == wd) cpuReq = 1'b0;
      end
      memValid = 1'b0;
      #1;
      chk("R2 memReq dropped", {31'd0, memReq}, 32'd0);
    end
  endtask

  task automatic doWrite(input logic [7:0] tg, input logic [6:0] ix);
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = 1'b1; cpuAddr = {13'd0, tg, ix, 2'd0};
    #1;
    chk("R9 write acknowledged", {31'd0, cpuReady}, 32'd1);
    @(negedge clk);
    cpuReq = 1'b0; cpuWr = 1'b0;
    #1;
    chk("R9 write no memory access", {31'd0, memReq}, 32'd0);
  endtask

  task automatic doMnt(input logic [1:0] op, input logic [6:0] ix, input logic wy);
    @(negedge clk);
    mntValid = 1'b1; mntOp = op; mntIndex = ix; mntWay = wy;
    #1;
    chk("R10 maintenance accepted", {31'd0, mntReady}, 32'd1);
    @(negedge clk);
    mntValid = 1'b0; mntOp = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset memReq", {31'd0, memReq}, 32'd0);
    chk("R11 reset cpuReady", {31'd0, cpuReady}, 32'd0);
    chk("R11 reset mntReady", {31'd0, mntReady}, 32'd1);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        3'd0: doRead(VEC[i].tag, VEC[i].idx, VEC[i].word, VEC[i].miss);
        3'd1: doWrite(VEC[i].tag, VEC[i].idx);
        3'd2: doMnt(2'd1, VEC[i].idx, VEC[i].way);
        3'd3: doMnt(2'd2, VEC[i].idx, VEC[i].way);
        default: doMnt(2'd3, VEC[i].idx, VEC[i].way);
      endcase
    end

    // R10: maintenance wins over a simultaneous read of a cached line
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = 1'b0; cpuAddr = {13'd0, 8'd1, 7'd6, 2'd0};
    mntValid = 1'b1; mntOp = 2'd0; mntIndex = 7'd6; mntWay = 1'b0;
    #1;
    chk("R10 cpu waits for maintenance", {31'd0, cpuReady}, 32'd0);
    chk("R10 maintenance taken", {31'd0, mntReady}, 32'd1);
    @(negedge clk);
    mntValid = 1'b0;
    #1;
    chk("R10 cpu served after", {31'd0, cpuReady}, 32'd1);
    chk("R8 nop op keeps line", cpuRdata, memWord({13'd0, 8'd1, 7'd6, 2'd0}));
    @(negedge clk);
    cpuReq = 1'b0;

    // R8: invalidate way0 of set 6, the line must miss again
    doMnt(2'd3, 7'd6, 1'b0);
    doRead(8'd1, 7'd6, 2'd3, 1'b1);

    // R11: reset clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doRead(8'd1, 7'd6, 2'd0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule